// File: doc/BRIEF.md
# SPI Controller Register Front End

This block is the register-facing half of an SPI controller. A host reaches it over a simple 32-bit register bus with single-cycle access. Behind the registers sit an 8-word transmit queue and an 8-word receive queue. Each queue has a programmable 4-bit threshold and a flush control. A serial engine, which is outside this block, takes transmit words and delivers received words through word-level handshakes.

The block stores the clock, word and frame setup fields and drives them to the engine. It reports busy and receive-data presence in a status register. It tracks three sticky events: transmit done, receive done and receive overrun. The interrupt line combines these events with their enable bits. Two DMA request lines follow the queue levels against the thresholds.

A host typically works in this order:
1. Write the setup registers and set the enable bit.
2. Fill the transmit queue through the data address.
3. Wait for the interrupt or a DMA request.
4. Drain the receive queue through the same data address.

Top module: `spi_regfront`

## Requirements
- R1: After reset, every register reads 0. This covers the control register (word 0x00), the setup registers (0x04, 0x08, 0x0C, 0x10), interrupt enable (0x18), interrupt status (0x1C), queue control (0x20) and status (0x14). After reset, `irq`, `dma_tx_req`, `dma_rx_req` and `eng_tx_valid` are all 0.
- R2: Each setup register keeps only its defined bits and reads back the value written under its mask:
  - control 0x00: mask 0x1 (bit 0 is the enable)
  - clock setup 0x04: mask 0x70FF
  - transmit word setup 0x08: mask 0x3FFF
  - receive word setup 0x0C: mask 0x3F
  - frame setup 0x10: mask 0xC000
  - interrupt enable 0x18: mask 0x1F
  - queue control 0x20: reads back only the thresholds, mask 0x0F0F
- R3: A write to 0x24 appends a word to the transmit queue. The engine receives the words in write order. A write while 8 words are queued is dropped.
- R4: A read of 0x24 returns the oldest received word and removes it. Status bit 0 is 1 exactly while the receive queue is non-empty. A read of an empty queue returns 0 and changes nothing.
- R5: If the engine delivers a word while the receive queue holds 8 words, that word is discarded and the overrun flag is set. The overrun flag is status bit 0 of 0x1C.
- R6: "Receive hit" means the receive level is non-zero and at least the receive threshold. The threshold is in bits 3:0 of 0x20. Receive hit is shown live in bit 9 of 0x1C. While receive hit holds and the transmit queue is empty, the receive-done flag (bit 3 of 0x1C) becomes set.
- R7: The transmit-done flag (bit 4 of 0x1C) becomes set when an engine take empties the transmit queue.
- R8: Writing 1 to bit 4, 3 or 0 of 0x1C clears the matching flag. A set condition present in the same cycle wins over the clear.
- R9: `irq` is 1 exactly when a flag is set and its enable bit is 1. The enable bits in 0x18 are bit 4 for transmit done, bit 3 for receive done and bit 0 for overrun.
- R10: `dma_tx_req` is 1 when 0x18 bit 2 is 1 and the free transmit entries are at least the transmit threshold (bits 11:8 of 0x20). `dma_rx_req` is 1 when 0x18 bit 1 is 1 and receive hit holds.
- R11: Writing 1 to bit 12 of 0x20 empties the transmit queue. Writing 1 to bit 4 of 0x20 empties the receive queue. The same write stores the thresholds, and both flush bits read back as 0.
- R12: `eng_tx_valid` is 1 only while the enable bit is 1 and the transmit queue is non-empty. Clearing the enable bit therefore stops the hand-over at a word boundary. Status bit 7 of 0x14 mirrors `eng_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| eng_tx_valid | output | 1 | Transmit word available to the engine |
| eng_tx_ready | input | 1 | Engine takes the transmit word |
| eng_tx_data | output | DATA_W | Oldest transmit word |
| eng_rx_valid | input | 1 | Engine delivers a received word |
| eng_rx_data | input | DATA_W | Received word |
| eng_busy | input | 1 | Engine is shifting |
| ctl_en | output | 1 | Controller enable |
| cfg_clock | output | 16 | Clock setup field |
| cfg_txword | output | 14 | Transmit word setup field |
| cfg_rxword | output | 6 | Receive word setup field |
| cfg_frame | output | 2 | Frame setup bits 15:14 |
| irq | output | 1 | Interrupt request |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The bench builds the block with its defaults: 32-bit words, 8-entry queues and a 6-bit address. With these values both queues can be filled past capacity within a few dozen bus cycles. This reaches the dropped ninth transmit write, the ninth-word receive overrun, and the threshold extremes 0 and 8 against real queue levels. The random phase mixes host pushes and pops with engine takes and deliveries, so the pointers wrap many times while the order of the queued words is checked.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
    localparam int THR_W = 4;

    // word indices of the register map
    localparam logic [3:0] IDX_CTL  = 4'd0;
    localparam logic [3:0] IDX_CLK  = 4'd1;
    localparam logic [3:0] IDX_TXW  = 4'd2;
    localparam logic [3:0] IDX_RXW  = 4'd3;
    localparam logic [3:0] IDX_FRM  = 4'd4;
    localparam logic [3:0] IDX_STAT = 4'd5;
    localparam logic [3:0] IDX_IE   = 4'd6;
    localparam logic [3:0] IDX_IRQ  = 4'd7;
    localparam logic [3:0] IDX_FIFO = 4'd8;
    localparam logic [3:0] IDX_DATA = 4'd9;

    // flag vector positions inside the sticky event block
    localparam int EV_OVR = 0;
    localparam int EV_RXC = 1;
    localparam int EV_TXC = 2;
    localparam int EV_N   = 3;

    typedef struct packed {
        logic             en;
        logic [15:0]      clk;
        logic [13:0]      txw;
        logic [5:0]       rxw;
        logic [1:0]       frm;
        logic [4:0]       ie;
        logic [THR_W-1:0] txth;
        logic [THR_W-1:0] rxth;
    } regs_t;
endpackage

// File: rtl/spi_rf_fifo.sv
module spi_rf_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [LVL_W-1:0]        cnt;
    } fifo_t;

    fifo_t st_d, st_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != LVL_W'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wp] = wdata;
                st_d.wp           = bump(st_q.wp);
            end
            if (do_pop) st_d.rp = bump(st_q.rp);
            st_d.cnt = st_q.cnt + LVL_W'(do_push) - LVL_W'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.mem[st_q.rp];
    assign level = st_q.cnt;
    assign full  = (st_q.cnt == LVL_W'(DEPTH));
    assign empty = (st_q.cnt == '0);

    // R3: occupancy never exceeds the depth
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));
    // R3: a push into a full queue with no pop leaves the level unchanged
    a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> $stable(level));
    // R11: a flush leaves the queue empty
    a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/spi_rf_irq.sv
module spi_rf_irq #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] en,
    output logic [N-1:0] pend,
    output logic         irq
);
    logic [N-1:0] pend_d, pend_q;

    always_comb begin
        pend_d = (pend_q & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;
    assign irq  = |(pend_q & en);

    // R8: a clear without a concurrent set leaves the flag low
    a_r8_clear_wins_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~set)) |=> ((pend & $past(clr & ~set)) == '0));
    // R8: a set event is never lost, even against a clear
    a_r8_set_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((pend & $past(set)) == $past(set)));
endmodule

// File: rtl/spi_regfront.sv
module spi_regfront
    import spi_rf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 6,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              eng_tx_valid,
    input  logic              eng_tx_ready,
    output logic [DATA_W-1:0] eng_tx_data,
    input  logic              eng_rx_valid,
    input  logic [DATA_W-1:0] eng_rx_data,
    input  logic              eng_busy,
    output logic              ctl_en,
    output logic [15:0]       cfg_clock,
    output logic [13:0]       cfg_txword,
    output logic [5:0]        cfg_rxword,
    output logic [1:0]        cfg_frame,
    output logic              irq,
    output logic              dma_tx_req,
    output logic              dma_rx_req
);
    regs_t regs_d, regs_q;

    logic [3:0] idx;
    logic       wr, rd;
    logic       tx_push, tx_pop, tx_flush, rx_push, rx_pop, rx_flush;
    logic [DATA_W-1:0] rx_head;
    logic [LVL_W-1:0]  tx_level, rx_level;
    logic tx_full, tx_empty, rx_full, rx_empty, rx_hit;
    logic [EV_N-1:0] ev_set, ev_clr, ev_en, ev_pend;

    assign idx = bus_addr[ADDR_W-1:2];
    assign wr  = bus_sel && bus_we;
    assign rd  = bus_sel && !bus_we;

    assign tx_push  = wr && (idx == IDX_DATA);
    assign rx_pop   = rd && (idx == IDX_DATA);
    assign tx_flush = wr && (idx == IDX_FIFO) && bus_wdata[12];
    assign rx_flush = wr && (idx == IDX_FIFO) && bus_wdata[4];

    assign eng_tx_valid = regs_q.en && !tx_empty;
    assign tx_pop       = eng_tx_valid && eng_tx_ready;
    assign rx_push      = eng_rx_valid && !rx_full;

    spi_rf_fifo #(.W(DATA_W), .DEPTH(DEPTH)) i_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(tx_push), .wdata(bus_wdata[DATA_W-1:0]),
        .pop(tx_pop), .rdata(eng_tx_data),
        .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    spi_rf_fifo #(.W(DATA_W), .DEPTH(DEPTH)) i_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(rx_push), .wdata(eng_rx_data),
        .pop(rx_pop), .rdata(rx_head),
        .level(rx_level), .full(rx_full), .empty(rx_empty)
    );

    assign rx_hit = !rx_empty && (int'(rx_level) >= int'(regs_q.rxth));

    assign ev_set[EV_OVR] = eng_rx_valid && rx_full;
    assign ev_set[EV_RXC] = rx_hit && tx_empty;
    assign ev_set[EV_TXC] = tx_pop && (tx_level == LVL_W'(1)) && !tx_flush;

    assign ev_clr = (wr && idx == IDX_IRQ) ?
                    {bus_wdata[4], bus_wdata[3], bus_wdata[0]} : '0;
    assign ev_en  = {regs_q.ie[4], regs_q.ie[3], regs_q.ie[0]};

    spi_rf_irq #(.N(EV_N)) i_evt (
        .clk(clk), .rst_n(rst_n), .set(ev_set), .clr(ev_clr),
        .en(ev_en), .pend(ev_pend), .irq(irq)
    );

    always_comb begin
        regs_d = regs_q;
        if (wr) begin
            unique case (idx)
                IDX_CTL:  regs_d.en  = bus_wdata[0];
                IDX_CLK:  regs_d.clk = bus_wdata[15:0] & 16'h70FF;
                IDX_TXW:  regs_d.txw = bus_wdata[13:0];
                IDX_RXW:  regs_d.rxw = bus_wdata[5:0];
                IDX_FRM:  regs_d.frm = bus_wdata[15:14];
                IDX_IE:   regs_d.ie  = bus_wdata[4:0];
                IDX_FIFO: begin
                    regs_d.txth = bus_wdata[8 +: THR_W];
                    regs_d.rxth = bus_wdata[0 +: THR_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (idx)
            IDX_CTL:  bus_rdata[0]     = regs_q.en;
            IDX_CLK:  bus_rdata[15:0]  = regs_q.clk;
            IDX_TXW:  bus_rdata[13:0]  = regs_q.txw;
            IDX_RXW:  bus_rdata[5:0]   = regs_q.rxw;
            IDX_FRM:  bus_rdata[15:14] = regs_q.frm;
            IDX_STAT: begin
                bus_rdata[7] = eng_busy;
                bus_rdata[0] = !rx_empty;
            end
            IDX_IE:   bus_rdata[4:0]   = regs_q.ie;
            IDX_IRQ: begin
                bus_rdata[9] = rx_hit;
                bus_rdata[4] = ev_pend[EV_TXC];
                bus_rdata[3] = ev_pend[EV_RXC];
                bus_rdata[0] = ev_pend[EV_OVR];
            end
            IDX_FIFO: begin
                bus_rdata[8 +: THR_W] = regs_q.txth;
                bus_rdata[0 +: THR_W] = regs_q.rxth;
            end
            IDX_DATA: if (!rx_empty) bus_rdata[DATA_W-1:0] = rx_head;
            default: ;
        endcase
    end

    assign ctl_en     = regs_q.en;
    assign cfg_clock  = regs_q.clk;
    assign cfg_txword = regs_q.txw;
    assign cfg_rxword = regs_q.rxw;
    assign cfg_frame  = regs_q.frm;
    assign dma_tx_req = regs_q.ie[2] &&
                        (int'(DEPTH) - int'(tx_level) >= int'(regs_q.txth));
    assign dma_rx_req = regs_q.ie[1] && rx_hit;

    // R5: a delivery into a full receive queue raises overrun next cycle
    a_r5_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_valid && rx_full) |=> ev_pend[EV_OVR]);
    // R5: a delivery into a full receive queue does not change its level
    a_r5_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_valid && rx_full && !rx_pop && !rx_flush) |=> $stable(rx_level));
    // R7: the take that empties the transmit queue sets transmit done
    a_r7_txdone: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && tx_level == LVL_W'(1) && !tx_flush) |=> ev_pend[EV_TXC]);
    // R10: no receive DMA request without data to fetch
    a_r10_dma_rx_data: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rx_req |-> (rx_level != '0));
    // R12: after the enable drops, no transmit word is offered
    a_r12_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && idx == IDX_CTL && !bus_wdata[0]) |=> !eng_tx_valid);
endmodule

// File: tb/test_spi_regfront.sv
`timescale 1ns/1ps
module test_spi_regfront;
    localparam int DW = 32;
    localparam int DEPTH = 8;
    localparam logic [5:0] A_CTL = 6'h00, A_CLK = 6'h04, A_TXW = 6'h08,
        A_RXW = 6'h0C, A_FRM = 6'h10, A_STAT = 6'h14, A_IE = 6'h18,
        A_IRQ = 6'h1C, A_FIFO = 6'h20, A_DATA = 6'h24;

    logic clk = 0, rst_n = 0;
    logic bus_sel = 0, bus_we = 0;
    logic [5:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic eng_tx_valid, eng_tx_ready = 0, eng_rx_valid = 0, eng_busy = 0;
    logic [DW-1:0] eng_tx_data, eng_rx_data = '0;
    logic ctl_en, irq, dma_tx_req, dma_rx_req;
    logic [15:0] cfg_clock;
    logic [13:0] cfg_txword;
    logic [5:0] cfg_rxword;
    logic [1:0] cfg_frame;

    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    spi_regfront i_spi_regfront (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_tx_valid(eng_tx_valid), .eng_tx_ready(eng_tx_ready),
        .eng_tx_data(eng_tx_data), .eng_rx_valid(eng_rx_valid),
        .eng_rx_data(eng_rx_data), .eng_busy(eng_busy), .ctl_en(ctl_en),
        .cfg_clock(cfg_clock), .cfg_txword(cfg_txword),
        .cfg_rxword(cfg_rxword), .cfg_frame(cfg_frame), .irq(irq),
        .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
    );

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic eng_take(output logic v, output logic [31:0] d);
        @(negedge clk);
        eng_tx_ready = 1;
        #1 v = eng_tx_valid; d = eng_tx_data;
        @(negedge clk);
        eng_tx_ready = 0;
    endtask

    task automatic eng_put(input logic [31:0] d);
        @(negedge clk);
        eng_rx_valid = 1; eng_rx_data = d;
        @(negedge clk);
        eng_rx_valid = 0;
    endtask

    function automatic logic [31:0] pat(input int i);
        return 32'hA5000000 ^ (i * 32'h01010101);
    endfunction

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL R1 watchdog expired actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic v;
        logic [31:0] txm[$];
        logic [31:0] rxm[$];

        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        bus_rd(A_CTL, r);  check("R1 ctl", r, 0);
        bus_rd(A_CLK, r);  check("R1 clk", r, 0);
        bus_rd(A_TXW, r);  check("R1 txw", r, 0);
        bus_rd(A_RXW, r);  check("R1 rxw", r, 0);
        bus_rd(A_FRM, r);  check("R1 frm", r, 0);
        bus_rd(A_IE, r);   check("R1 ie", r, 0);
        bus_rd(A_IRQ, r);  check("R1 irq status", r, 0);
        bus_rd(A_FIFO, r); check("R1 fifo ctl", r, 0);
        bus_rd(A_STAT, r); check("R1 status", r, 0);
        check("R1 outputs", {28'd0, irq, dma_tx_req, dma_rx_req, eng_tx_valid}, 0);

        // R2 field masks
        bus_wr(A_CTL, '1);  bus_rd(A_CTL, r);  check("R2 ctl", r, 32'h1);
        bus_wr(A_CLK, '1);  bus_rd(A_CLK, r);  check("R2 clk", r, 32'h70FF);
        bus_wr(A_TXW, '1);  bus_rd(A_TXW, r);  check("R2 txw", r, 32'h3FFF);
        bus_wr(A_RXW, '1);  bus_rd(A_RXW, r);  check("R2 rxw", r, 32'h3F);
        bus_wr(A_FRM, '1);  bus_rd(A_FRM, r);  check("R2 frm", r, 32'hC000);
        bus_wr(A_IE, '1);   bus_rd(A_IE, r);   check("R2 ie", r, 32'h1F);
        bus_wr(A_FIFO, '1); bus_rd(A_FIFO, r); check("R2 fifo ctl", r, 32'h0F0F);
        check("R2 cfg ports", {cfg_clock, cfg_txword[7:0], cfg_rxword, cfg_frame},
              {16'h70FF, 8'hFF, 6'h3F, 2'h3});
        bus_wr(A_IE, 0); bus_wr(A_FIFO, 0); bus_wr(A_CTL, 0);

        // R12 enable gating and busy mirror
        bus_wr(A_DATA, 32'h11223344);
        eng_take(v, r); check("R12 gated while disabled", {31'd0, v}, 0);
        eng_busy = 1;
        bus_rd(A_STAT, r); check("R12 busy bit", r, 32'h80);
        eng_busy = 0;
        bus_wr(A_CTL, 1);
        eng_take(v, r); check("R12 valid when enabled", {31'd0, v}, 1);
        check("R3 first word", r, 32'h11223344);
        // R7 transmit done
        bus_rd(A_IRQ, r); check("R7 txdone set", r & 32'h10, 32'h10);
        bus_wr(A_IRQ, 32'h10);
        bus_rd(A_IRQ, r); check("R8 txdone cleared", r & 32'h10, 0);

        // R3 order and drop when full
        for (int i = 0; i < 9; i++) bus_wr(A_DATA, pat(i));
        for (int i = 0; i < 8; i++) begin
            eng_take(v, r);
            check("R3 tx order", r, pat(i));
        end
        eng_take(v, r); check("R3 ninth write dropped", {31'd0, v}, 0);

        // R5 overrun and R4 read order
        bus_wr(A_IRQ, 32'h19);
        for (int i = 0; i < 9; i++) eng_put(pat(i + 20));
        bus_rd(A_IRQ, r); check("R5 overrun flag", r & 32'h1, 1);
        for (int i = 0; i < 8; i++) begin
            bus_rd(A_DATA, r);
            check("R4 rx order", r, pat(i + 20));
        end
        bus_rd(A_STAT, r); check("R4 rx empty status", r, 0);
        bus_rd(A_DATA, r); check("R4 empty read zero", r, 0);

        // R6 receive threshold
        bus_wr(A_FIFO, 32'h0013);
        bus_wr(A_IRQ, 32'h19);
        eng_put(1); eng_put(2);
        bus_rd(A_IRQ, r); check("R6 below threshold", r & 32'h208, 0);
        eng_put(3);
        bus_rd(A_IRQ, r); check("R6 threshold reached", r & 32'h208, 32'h208);
        bus_wr(A_FIFO, 32'h0013);
        bus_wr(A_IRQ, 32'h19);
        bus_wr(A_CTL, 0);
        bus_wr(A_DATA, 32'h77);
        eng_put(4); eng_put(5); eng_put(6);
        bus_rd(A_IRQ, r); check("R6 hit but tx pending", r & 32'h208, 32'h200);
        bus_wr(A_CTL, 1);
        eng_take(v, r);
        bus_rd(A_IRQ, r); check("R6 rxdone after tx empty", r & 32'h208, 32'h208);
        // R8 set beats clear
        bus_wr(A_IRQ, 32'h08);
        bus_rd(A_IRQ, r); check("R8 set priority", r & 32'h8, 32'h8);
        for (int i = 0; i < 3; i++) bus_rd(A_DATA, r);
        bus_wr(A_IRQ, 32'h19);
        bus_rd(A_IRQ, r); check("R8 all cleared", r, 0);

        // R9 interrupt combination
        bus_wr(A_FIFO, 32'h0010);
        bus_wr(A_IE, 32'h01);
        for (int i = 0; i < 9; i++) eng_put(i);
        check("R9 irq on overrun", {31'd0, irq}, 1);
        bus_wr(A_FIFO, 32'h0010);
        bus_wr(A_IRQ, 32'h19);
        bus_wr(A_DATA, 5);
        eng_take(v, r);
        check("R9 txdone masked", {31'd0, irq}, 0);
        bus_wr(A_IE, 32'h10);
        check("R9 txdone enabled", {31'd0, irq}, 1);
        bus_wr(A_IRQ, 32'h10);
        check("R9 irq cleared", {31'd0, irq}, 0);

        // R10 DMA requests
        bus_wr(A_FIFO, 32'h0802);
        bus_wr(A_IE, 32'h06);
        check("R10 dma tx all free", {31'd0, dma_tx_req}, 1);
        bus_wr(A_CTL, 0);
        bus_wr(A_DATA, 9);
        check("R10 dma tx below", {31'd0, dma_tx_req}, 0);
        eng_put(1);
        check("R10 dma rx below", {31'd0, dma_rx_req}, 0);
        eng_put(2);
        check("R10 dma rx at threshold", {31'd0, dma_rx_req}, 1);
        bus_wr(A_IE, 32'h04);
        check("R10 dma rx masked", {31'd0, dma_rx_req}, 0);

        // R11 flush
        bus_wr(A_DATA, 10); bus_wr(A_DATA, 11);
        bus_wr(A_FIFO, 32'h1512);
        bus_wr(A_CTL, 1);
        eng_take(v, r); check("R11 tx flushed", {31'd0, v}, 0);
        bus_rd(A_STAT, r); check("R11 rx flushed", r, 0);
        bus_rd(A_FIFO, r); check("R11 thresholds kept", r, 32'h0502);
        bus_wr(A_IE, 0); bus_wr(A_FIFO, 0); bus_wr(A_IRQ, 32'h19);

        // random traffic against queue models
        void'($urandom(32'h5EED));
        for (int n = 0; n < 400; n++) begin
            logic [31:0] w;
            w = $urandom;
            case ($urandom % 4)
                0: begin
                    bus_wr(A_DATA, w);
                    if (txm.size() < DEPTH) txm.push_back(w);
                end
                1: begin
                    eng_take(v, r);
                    check("R3 random tx valid", {31'd0, v}, {31'd0, txm.size() != 0});
                    if (txm.size() != 0) check("R3 random tx data", r, txm.pop_front());
                end
                2: begin
                    eng_put(w);
                    if (rxm.size() < DEPTH) rxm.push_back(w);
                end
                default: begin
                    bus_rd(A_DATA, r);
                    if (rxm.size() != 0) check("R4 random rx data", r, rxm.pop_front());
                    else check("R4 random empty read", r, 0);
                end
            endcase
        end
        bus_rd(A_STAT, r);
        check("R4 random status", r, {31'd0, rxm.size() != 0});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule